// File: doc/BRIEF.md
# Passive-Parallel FPGA Configuration Sequencer

This block walks a target FPGA through a full passive-parallel load for a host. After a start command it checks the mode-select straps and waits for the target's configuration pins to go quiet. It then takes over the target's control pins and selects the chip. Next it pulses the configuration-reset line and confirms the target is ready. Finally it opens the control and data path so that an external streamer can push the image.

When the host reports the end of the stream, the sequencer waits for the target to finish. It requests a burst of extra data clocks and waits for user mode. It then closes the window, hands the pins back and checks the final pin state. The result is a one-cycle completion pulse and a two-bit result code. The code reads 0 for success, 1 for a bad mode-select, 2 for a timeout and 3 for a failed status or done check.

Every wait has its own bound. Pin waits use a millisecond timeout built from a prescaler. The done poll uses a count of poll cycles. The data streaming and the data clock divider live outside this block.

Top module: `fpp_cfg_seq`

## Requirements
- R1: After reset the block is idle: busy 0, done 0, result 0, chip enable high (deselected), configuration-reset drive high, both path enables 0, PR request 0, both output enables 0, and all four active-low override controls 1.
- R2: On start, a mode-select value with bit 1 or bit 2 set ends the run with result 1 and no pin is driven; values 0 and 1 proceed.
- R3: After the mode check, no drive changes until both the target's configuration-reset pin and status pin read low. If that does not happen within the timeout, the run ends with result 2.
- R4: Once both pins are low, the sequencer first sets the quiet state: chip enable high, PR request 0, path enables 0, configuration-reset driven high, both output enables 0. It then sets the override controls: config and configuration-reset overrides 0, status and done overrides 1. After that it drives chip enable low, while configuration-reset is still driven high.
- R5: After a second wait for both pins low, configuration-reset is driven low until the status pin reads low, then driven high. The sequencer then waits for the status pin to read high. Each of these waits ends with result 2 on timeout, and configuration-reset is never driven low while idle.
- R6: After the pulse, a done pin of 1 or a done output-enable of 0 ends the run with result 3. Otherwise both path enables go to 1, and the data path is only ever enabled with the chip selected and the config override active.
- R7: After the host marks the end of the stream, the done pin is polled once per cycle for up to POLL_LIMIT cycles. Done high wins first. Otherwise a low status pin ends the run with result 3, and an exhausted poll ends it with result 2.
- R8: After done, the extra-clock request is held high with the count output equal to EXTRA_DCLKS, and only while the data path is enabled, until acknowledged. The sequencer then waits for user mode; a timeout on either wait ends the run with result 2.
- R9: When user mode is seen, both path enables go to 0, the config and configuration-reset override controls go to 1, and chip enable goes high.
- R10: The final check gives result 0 only if user mode, the done pin and the status pin all read high; otherwise result 3.
- R11: Done is a single-cycle pulse. The result is held until the next accepted start. After any error all drives return to their reset values.
- R12: A pin or user-mode timeout fires TICKS_PER_MS x TIMEOUT_MS cycles after the wait begins, give or take two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start a configuration run (ignored while busy) |
| msel_i | input | 3 | Target mode-select straps |
| tgt_ncfg_i | input | 1 | Target configuration-reset pin readback (active low) |
| tgt_nstat_i | input | 1 | Target status pin readback (active low) |
| tgt_cdone_i | input | 1 | Target done pin readback |
| tgt_cdone_oe_i | input | 1 | Target done output-enable readback |
| tgt_user_i | input | 1 | Target user-mode flag |
| stream_done_i | input | 1 | Host marks the end of the image stream |
| dclk_ack_i | input | 1 | Extra data clocks have been issued |
| drv_nce_o | output | 1 | Chip enable, active low |
| drv_pr_req_o | output | 1 | Partial-reconfiguration request |
| ctl_path_en_o | output | 1 | Control path enable |
| data_path_en_o | output | 1 | Data path enable |
| drv_ncfg_o | output | 1 | Configuration-reset drive, active low |
| drv_nstat_oe_o | output | 1 | Host output enable for the status pin |
| drv_cdone_oe_o | output | 1 | Host output enable for the done pin |
| cfg_ovr_n_o | output | 1 | Config override enable, active low |
| ncfg_ovr_n_o | output | 1 | Configuration-reset override enable, active low |
| nstat_ovr_n_o | output | 1 | Status override enable, active low |
| cdone_ovr_n_o | output | 1 | Done override enable, active low |
| dclk_req_o | output | 1 | Request for extra data clocks |
| dclk_num_o | output | DCLK_W | Number of extra data clocks requested |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 2 | Result code: 0 ok, 1 mode, 2 timeout, 3 check |

## Verification
The bench builds the block with TICKS_PER_MS = 4 and TIMEOUT_MS = 3, so each pin wait times out after twelve cycles, and with POLL_LIMIT = 20. These values let the bench reach every timeout branch and the exhausted done poll in a few dozen cycles, and time the timeout edge to the cycle. EXTRA_DCLKS keeps its default of 15, so the count output is checked at its real value.

// File: rtl/fpp_cfg_pkg.sv
// Package: shared types for the passive-parallel configuration sequencer.
// Holds the sequencer state encoding, the drive-update actions, the result
// codes and the packed drive register with its released value.
package fpp_cfg_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_MODE,
        ST_QUIET1,
        ST_OVERRIDE,
        ST_SELECT,
        ST_QUIET2,
        ST_PULSE_LO,
        ST_PULSE_HI,
        ST_POSTCHK,
        ST_STREAM,
        ST_POLL,
        ST_XCLK,
        ST_USER,
        ST_FINAL
    } seq_state_t;

    typedef enum logic [3:0] {
        ACT_NONE,
        ACT_QUIESCE,
        ACT_OVERRIDE,
        ACT_SELECT,
        ACT_NCFG_LO,
        ACT_NCFG_HI,
        ACT_OPEN,
        ACT_CLOSE,
        ACT_RELEASE
    } drv_act_t;

    typedef enum logic [1:0] {
        RES_OK    = 2'd0,
        RES_MODE  = 2'd1,
        RES_TIME  = 2'd2,
        RES_CHECK = 2'd3
    } seq_res_t;

    typedef struct packed {
        logic nce;
        logic pr_req;
        logic ctl_en;
        logic data_en;
        logic ncfg;
        logic nstat_oe;
        logic cdone_oe;
        logic cfg_ovr_n;
        logic ncfg_ovr_n;
        logic nstat_ovr_n;
        logic cdone_ovr_n;
    } drv_t;

    localparam drv_t DRV_RELEASED = '{
        nce:         1'b1,
        pr_req:      1'b0,
        ctl_en:      1'b0,
        data_en:     1'b0,
        ncfg:        1'b1,
        nstat_oe:    1'b0,
        cdone_oe:    1'b0,
        cfg_ovr_n:   1'b1,
        ncfg_ovr_n:  1'b1,
        nstat_ovr_n: 1'b1,
        cdone_ovr_n: 1'b1
    };

endpackage

// File: rtl/seq_counter.sv
// Module: seq_counter
// A cycle counter with a synchronous clear and a count enable.
// With WRAP=1 it runs 0..LIMIT-1 and hit_o marks the enabled wrap cycle
// (a prescaler tick). With WRAP=0 it saturates at LIMIT and hit_o stays
// high once the limit is reached.
// Assumes LIMIT >= 1.
module seq_counter #(
    parameter int unsigned LIMIT = 4,
    parameter bit          WRAP  = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic en_i,
    output logic hit_o
);
    localparam int unsigned      CW     = $clog2(LIMIT + 1);
    localparam logic [CW-1:0]    LIM    = CW'(LIMIT);
    localparam logic [CW-1:0]    LIM_M1 = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    generate
        if (WRAP) begin : g_wrap
            // Count up with wrap at LIMIT-1, cleared on request.
            always_ff @(posedge clk) begin
                if (!rst_n || clr_i) begin
                    cnt_q <= '0;
                end else if (en_i) begin
                    cnt_q <= (cnt_q == LIM_M1) ? '0 : cnt_q + 1'b1;
                end
            end
            assign hit_o = en_i && (cnt_q == LIM_M1);
        end else begin : g_sat
            // Count up and stop at LIMIT, cleared on request.
            always_ff @(posedge clk) begin
                if (!rst_n || clr_i) begin
                    cnt_q <= '0;
                end else if (en_i && (cnt_q != LIM)) begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
            assign hit_o = (cnt_q == LIM);
        end
    endgenerate

endmodule

// File: rtl/cfg_drive_regs.sv
// Module: cfg_drive_regs
// Holds every pin drive towards the target in one packed register and
// applies one action per cycle as commanded by the sequencer.
// Assumes only one action is requested per cycle; reset gives the
// released drive set.
module cfg_drive_regs
    import fpp_cfg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  drv_act_t act_i,
    output drv_t     drv_o
);
    drv_t drv_q;
    drv_t drv_d;

    // Next drive value from the requested action.
    always_comb begin
        drv_d = drv_q;
        unique case (act_i)
            ACT_QUIESCE: begin
                drv_d.nce      = 1'b1;
                drv_d.pr_req   = 1'b0;
                drv_d.ctl_en   = 1'b0;
                drv_d.data_en  = 1'b0;
                drv_d.ncfg     = 1'b1;
                drv_d.nstat_oe = 1'b0;
                drv_d.cdone_oe = 1'b0;
            end
            ACT_OVERRIDE: begin
                drv_d.cfg_ovr_n   = 1'b0;
                drv_d.ncfg_ovr_n  = 1'b0;
                drv_d.nstat_ovr_n = 1'b1;
                drv_d.cdone_ovr_n = 1'b1;
            end
            ACT_SELECT:  drv_d.nce  = 1'b0;
            ACT_NCFG_LO: drv_d.ncfg = 1'b0;
            ACT_NCFG_HI: drv_d.ncfg = 1'b1;
            ACT_OPEN: begin
                drv_d.ctl_en  = 1'b1;
                drv_d.data_en = 1'b1;
            end
            ACT_CLOSE: begin
                drv_d.ctl_en     = 1'b0;
                drv_d.data_en    = 1'b0;
                drv_d.cfg_ovr_n  = 1'b1;
                drv_d.ncfg_ovr_n = 1'b1;
                drv_d.nce        = 1'b1;
            end
            ACT_RELEASE: drv_d = DRV_RELEASED;
            default:     drv_d = drv_q;
        endcase
    end

    // Drive register with released value on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) drv_q <= DRV_RELEASED;
        else        drv_q <= drv_d;
    end

    assign drv_o = drv_q;

endmodule

// File: rtl/cfg_seq_fsm.sv
// Module: cfg_seq_fsm
// Sequencer for one configuration run: mode check, quiet wait, takeover,
// reset pulse, post-reset check, data window, done poll, extra clocks,
// user-mode wait, close and final check. Drive changes are issued as
// actions on state transitions; waits are bounded by timer inputs.
// Assumes tmo_i and poll_end_i come from counters cleared by phase_clr_o.
module cfg_seq_fsm
    import fpp_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [2:0] msel_i,
    input  logic       tgt_ncfg_i,
    input  logic       tgt_nstat_i,
    input  logic       tgt_cdone_i,
    input  logic       tgt_cdone_oe_i,
    input  logic       tgt_user_i,
    input  logic       stream_done_i,
    input  logic       dclk_ack_i,
    input  logic       tmo_i,
    input  logic       poll_end_i,
    output drv_act_t   act_o,
    output logic       phase_clr_o,
    output logic       poll_en_o,
    output logic       dclk_req_o,
    output logic       busy_o,
    output logic       done_o,
    output logic [1:0] err_o
);
    seq_state_t state_q, state_d;
    logic       fin;
    seq_res_t   fin_res;
    logic       done_q;
    logic [1:0] err_q;
    logic       pins_quiet;

    assign pins_quiet = !tgt_ncfg_i && !tgt_nstat_i;

    // Next state, drive action and run completion.
    always_comb begin
        state_d = state_q;
        act_o   = ACT_NONE;
        fin     = 1'b0;
        fin_res = RES_OK;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = ST_MODE;
            end
            ST_MODE: begin
                if (msel_i[2:1] != 2'b00) begin
                    fin = 1'b1; fin_res = RES_MODE;
                end else begin
                    state_d = ST_QUIET1;
                end
            end
            ST_QUIET1: begin
                if (pins_quiet) begin
                    act_o = ACT_QUIESCE; state_d = ST_OVERRIDE;
                end else if (tmo_i) begin
                    fin = 1'b1; fin_res = RES_TIME;
                end
            end
            ST_OVERRIDE: begin
                act_o = ACT_OVERRIDE; state_d = ST_SELECT;
            end
            ST_SELECT: begin
                act_o = ACT_SELECT; state_d = ST_QUIET2;
            end
            ST_QUIET2: begin
                if (pins_quiet) begin
                    act_o = ACT_NCFG_LO; state_d = ST_PULSE_LO;
                end else if (tmo_i) begin
                    fin = 1'b1; fin_res = RES_TIME;
                end
            end
            ST_PULSE_LO: begin
                if (!tgt_nstat_i) begin
                    act_o = ACT_NCFG_HI; state_d = ST_PULSE_HI;
                end else if (tmo_i) begin
                    fin = 1'b1; fin_res = RES_TIME;
                end
            end
            ST_PULSE_HI: begin
                if (tgt_nstat_i) begin
                    state_d = ST_POSTCHK;
                end else if (tmo_i) begin
                    fin = 1'b1; fin_res = RES_TIME;
                end
            end
            ST_POSTCHK: begin
                if (!tgt_cdone_i && tgt_cdone_oe_i) begin
                    act_o = ACT_OPEN; state_d = ST_STREAM;
                end else begin
                    fin = 1'b1; fin_res = RES_CHECK;
                end
            end
            ST_STREAM: begin
                if (stream_done_i) state_d = ST_POLL;
            end
            ST_POLL: begin
                if (tgt_cdone_i) begin
                    state_d = ST_XCLK;
                end else if (!tgt_nstat_i) begin
                    fin = 1'b1; fin_res = RES_CHECK;
                end else if (poll_end_i) begin
                    fin = 1'b1; fin_res = RES_TIME;
                end
            end
            ST_XCLK: begin
                if (dclk_ack_i) begin
                    state_d = ST_USER;
                end else if (tmo_i) begin
                    fin = 1'b1; fin_res = RES_TIME;
                end
            end
            ST_USER: begin
                if (tgt_user_i) begin
                    act_o = ACT_CLOSE; state_d = ST_FINAL;
                end else if (tmo_i) begin
                    fin = 1'b1; fin_res = RES_TIME;
                end
            end
            ST_FINAL: begin
                fin = 1'b1;
                fin_res = (tgt_user_i && tgt_cdone_i && tgt_nstat_i) ? RES_OK : RES_CHECK;
            end
            default: begin
                fin = 1'b1; fin_res = RES_CHECK;
            end
        endcase
        if (fin) begin
            act_o   = ACT_RELEASE;
            state_d = ST_IDLE;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Completion pulse and held result code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 2'b00;
        end else begin
            done_q <= fin;
            if (fin)                                err_q <= fin_res;
            else if (state_q == ST_IDLE && start_i) err_q <= 2'b00;
        end
    end

    assign phase_clr_o = (state_d != state_q);
    assign poll_en_o   = (state_q == ST_POLL);
    assign dclk_req_o  = (state_q == ST_XCLK);
    assign busy_o      = (state_q != ST_IDLE);
    assign done_o      = done_q;
    assign err_o       = err_q;

endmodule

// File: rtl/fpp_cfg_seq.sv
// Module: fpp_cfg_seq (top)
// Passive-parallel configuration sequencer. Joins the sequencer, the drive
// register, a millisecond timeout (prescaler plus saturating ms counter)
// and a done-poll counter.
// Assumes inputs from the target are already synchronised to clk.
module fpp_cfg_seq
    import fpp_cfg_pkg::*;
#(
    parameter int unsigned TICKS_PER_MS = 100000,
    parameter int unsigned TIMEOUT_MS   = 1000,
    parameter int unsigned POLL_LIMIT   = 32'h0100_0000,
    parameter int unsigned EXTRA_DCLKS  = 15,
    localparam int unsigned DCLK_W      = $clog2(EXTRA_DCLKS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [2:0]        msel_i,
    input  logic              tgt_ncfg_i,
    input  logic              tgt_nstat_i,
    input  logic              tgt_cdone_i,
    input  logic              tgt_cdone_oe_i,
    input  logic              tgt_user_i,
    input  logic              stream_done_i,
    input  logic              dclk_ack_i,
    output logic              drv_nce_o,
    output logic              drv_pr_req_o,
    output logic              ctl_path_en_o,
    output logic              data_path_en_o,
    output logic              drv_ncfg_o,
    output logic              drv_nstat_oe_o,
    output logic              drv_cdone_oe_o,
    output logic              cfg_ovr_n_o,
    output logic              ncfg_ovr_n_o,
    output logic              nstat_ovr_n_o,
    output logic              cdone_ovr_n_o,
    output logic              dclk_req_o,
    output logic [DCLK_W-1:0] dclk_num_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [1:0]        err_o
);
    drv_act_t act;
    drv_t     drv;
    logic     phase_clr;
    logic     poll_en;
    logic     ms_tick;
    logic     tmo;
    logic     poll_end;

    cfg_seq_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start_i),
        .msel_i         (msel_i),
        .tgt_ncfg_i     (tgt_ncfg_i),
        .tgt_nstat_i    (tgt_nstat_i),
        .tgt_cdone_i    (tgt_cdone_i),
        .tgt_cdone_oe_i (tgt_cdone_oe_i),
        .tgt_user_i     (tgt_user_i),
        .stream_done_i  (stream_done_i),
        .dclk_ack_i     (dclk_ack_i),
        .tmo_i          (tmo),
        .poll_end_i     (poll_end),
        .act_o          (act),
        .phase_clr_o    (phase_clr),
        .poll_en_o      (poll_en),
        .dclk_req_o     (dclk_req_o),
        .busy_o         (busy_o),
        .done_o         (done_o),
        .err_o          (err_o)
    );

    cfg_drive_regs u_drv (
        .clk   (clk),
        .rst_n (rst_n),
        .act_i (act),
        .drv_o (drv)
    );

    seq_counter #(.LIMIT(TICKS_PER_MS), .WRAP(1'b1)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (phase_clr),
        .en_i  (1'b1),
        .hit_o (ms_tick)
    );

    seq_counter #(.LIMIT(TIMEOUT_MS), .WRAP(1'b0)) u_ms (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (phase_clr),
        .en_i  (ms_tick),
        .hit_o (tmo)
    );

    seq_counter #(.LIMIT(POLL_LIMIT), .WRAP(1'b0)) u_poll (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (phase_clr),
        .en_i  (poll_en),
        .hit_o (poll_end)
    );

    assign drv_nce_o      = drv.nce;
    assign drv_pr_req_o   = drv.pr_req;
    assign ctl_path_en_o  = drv.ctl_en;
    assign data_path_en_o = drv.data_en;
    assign drv_ncfg_o     = drv.ncfg;
    assign drv_nstat_oe_o = drv.nstat_oe;
    assign drv_cdone_oe_o = drv.cdone_oe;
    assign cfg_ovr_n_o    = drv.cfg_ovr_n;
    assign ncfg_ovr_n_o   = drv.ncfg_ovr_n;
    assign nstat_ovr_n_o  = drv.nstat_ovr_n;
    assign cdone_ovr_n_o  = drv.cdone_ovr_n;
    assign dclk_num_o     = DCLK_W'(EXTRA_DCLKS);

endmodule

// File: rtl/fpp_cfg_seq_chk.sv
// Module: fpp_cfg_seq_chk
// Port-level properties of the configuration sequencer, attached to every
// instance of the top module by the bind statement below.
module fpp_cfg_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tgt_nstat_i,
    input logic       tgt_cdone_i,
    input logic       tgt_user_i,
    input logic       drv_nce_o,
    input logic       ctl_path_en_o,
    input logic       data_path_en_o,
    input logic       drv_ncfg_o,
    input logic       cfg_ovr_n_o,
    input logic       ncfg_ovr_n_o,
    input logic       dclk_req_o,
    input logic       busy_o,
    input logic       done_o,
    input logic [1:0] err_o
);
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_idle_released_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (drv_nce_o && !ctl_path_en_o && !data_path_en_o && drv_ncfg_o
                     && cfg_ovr_n_o && ncfg_ovr_n_o));

    assert_ncfg_low_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !drv_ncfg_o |-> busy_o);

    assert_window_selected_R6: assert property (@(posedge clk) disable iff (!rst_n)
        data_path_en_o |-> (!drv_nce_o && !cfg_ovr_n_o));

    assert_xclk_in_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dclk_req_o |-> data_path_en_o);

    assert_final_ok_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_o == 2'd0) |-> $past(tgt_user_i && tgt_cdone_i && tgt_nstat_i));

    assert_mode_nodrive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_o == 2'd1) |-> drv_nce_o);

endmodule

bind fpp_cfg_seq fpp_cfg_seq_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .tgt_nstat_i    (tgt_nstat_i),
    .tgt_cdone_i    (tgt_cdone_i),
    .tgt_user_i     (tgt_user_i),
    .drv_nce_o      (drv_nce_o),
    .ctl_path_en_o  (ctl_path_en_o),
    .data_path_en_o (data_path_en_o),
    .drv_ncfg_o     (drv_ncfg_o),
    .cfg_ovr_n_o    (cfg_ovr_n_o),
    .ncfg_ovr_n_o   (ncfg_ovr_n_o),
    .dclk_req_o     (dclk_req_o),
    .busy_o         (busy_o),
    .done_o         (done_o),
    .err_o          (err_o)
);

// File: tb/sim_fpp_cfg_seq.sv
// Directed bench for fpp_cfg_seq: one task per scenario, each checking its
// own results at negative clock edges.
module sim_fpp_cfg_seq;
    localparam int TPM  = 4;
    localparam int TMS  = 3;
    localparam int POLL = 20;
    localparam int XDC  = 15;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [2:0] msel = 3'd0;
    logic p_ncfg = 1'b1, p_nstat = 1'b1, p_cdone = 1'b0, p_cdone_oe = 1'b1, p_user = 1'b0;
    logic sdone = 1'b0, ack = 1'b0;

    logic nce, prq, cen, den, ncfg, nsoe, cdoe, covr, ncovr, nsovr, cdovr, xreq, busy, done;
    logic [3:0] xnum;
    logic [1:0] err;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    fpp_cfg_seq #(.TICKS_PER_MS(TPM), .TIMEOUT_MS(TMS), .POLL_LIMIT(POLL), .EXTRA_DCLKS(XDC)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .msel_i(msel),
        .tgt_ncfg_i(p_ncfg), .tgt_nstat_i(p_nstat), .tgt_cdone_i(p_cdone),
        .tgt_cdone_oe_i(p_cdone_oe), .tgt_user_i(p_user),
        .stream_done_i(sdone), .dclk_ack_i(ack),
        .drv_nce_o(nce), .drv_pr_req_o(prq), .ctl_path_en_o(cen), .data_path_en_o(den),
        .drv_ncfg_o(ncfg), .drv_nstat_oe_o(nsoe), .drv_cdone_oe_o(cdoe),
        .cfg_ovr_n_o(covr), .ncfg_ovr_n_o(ncovr), .nstat_ovr_n_o(nsovr), .cdone_ovr_n_o(cdovr),
        .dclk_req_o(xreq), .dclk_num_o(xnum), .busy_o(busy), .done_o(done), .err_o(err)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pins_default();
        p_ncfg = 1'b1; p_nstat = 1'b1; p_cdone = 1'b0; p_cdone_oe = 1'b1;
        p_user = 1'b0; sdone = 1'b0; ack = 1'b0;
    endtask

    task automatic pulse_start(input logic [2:0] m);
        msel = m;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Wait for done; returns cycles waited (-1 if never).
    task automatic wait_done(input int lim, output int n);
        n = -1;
        for (int i = 0; i < lim; i++) begin
            if (done === 1'b1) begin n = i; break; end
            @(negedge clk);
        end
    endtask

    task automatic expect_end(input string req, input int code);
        int n;
        wait_done(60, n);
        chk(n >= 0, req, "done seen", n, 0);
        chk(err === code[1:0], req, "result", int'(err), code);
        chk(nce === 1'b1 && den === 1'b0 && ncfg === 1'b1 && covr === 1'b1 && ncovr === 1'b1,
            "R11", "drives released", int'({nce, den, ncfg, covr, ncovr}), 5'b10111);
        cyc(1);
        chk(done === 1'b0, "R11", "done one cycle", int'(done), 0);
        chk(err === code[1:0], "R11", "result held", int'(err), code);
    endtask

    // Run up to the open data window, checking the takeover on the way.
    task automatic to_window(input logic [2:0] m, input bit oe_ok);
        int k;
        pins_default();
        pulse_start(m);
        cyc(5);
        chk(nce === 1'b1 && covr === 1'b1, "R3", "no drive before quiet", int'(nce), 1);
        p_ncfg = 1'b0; p_nstat = 1'b0;
        k = 0;
        while (nce !== 1'b0 && k < 20) begin @(negedge clk); k++; end
        chk(nce === 1'b0, "R4", "chip selected", int'(nce), 0);
        chk({prq, cen, den, ncfg, nsoe, cdoe} === 6'b000100, "R4", "quiet drives",
            int'({prq, cen, den, ncfg, nsoe, cdoe}), 6'b000100);
        chk({covr, ncovr, nsovr, cdovr} === 4'b0011, "R4", "overrides",
            int'({covr, ncovr, nsovr, cdovr}), 4'b0011);
        k = 0;
        while (ncfg !== 1'b0 && k < 20) begin @(negedge clk); k++; end
        chk(ncfg === 1'b0, "R5", "reset pulse low", int'(ncfg), 0);
        k = 0;
        while (ncfg !== 1'b1 && k < 20) begin @(negedge clk); k++; end
        chk(ncfg === 1'b1, "R5", "reset pulse high", int'(ncfg), 1);
        cyc(3);
        chk(cen === 1'b0 && busy === 1'b1, "R5", "waits for status high", int'(cen), 0);
        p_cdone_oe = oe_ok;
        p_nstat = 1'b1; p_ncfg = 1'b1;
        if (oe_ok) begin
            k = 0;
            while (cen !== 1'b1 && k < 20) begin @(negedge clk); k++; end
            chk(cen === 1'b1 && den === 1'b1, "R6", "window open", int'({cen, den}), 3);
        end
    endtask

    task automatic t_reset();
        chk(busy === 1'b0 && done === 1'b0 && err === 2'd0, "R1", "idle status",
            int'({busy, done, err}), 0);
        chk({nce, prq, cen, den, ncfg, nsoe, cdoe, covr, ncovr, nsovr, cdovr} === 11'b10001001111,
            "R1", "released drives",
            int'({nce, prq, cen, den, ncfg, nsoe, cdoe, covr, ncovr, nsovr, cdovr}), 11'b10001001111);
    endtask

    task automatic t_bad_mode();
        pins_default();
        pulse_start(3'b010);
        expect_end("R2", 1);
        pulse_start(3'b100);
        expect_end("R2", 1);
    endtask

    task automatic t_quiet_timeout();
        int n;
        pins_default();
        msel = 3'd0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(60, n);
        // start edge, mode check edge, then TPM*TMS cycles and a finishing edge
        chk(n + 1 >= TPM * TMS && n + 1 <= TPM * TMS + 4, "R12", "timeout length", n + 1, TPM * TMS + 2);
        chk(err === 2'd2, "R3", "quiet timeout result", int'(err), 2);
        cyc(1);
    endtask

    task automatic t_full_ok(input logic [2:0] m);
        int k;
        to_window(m, 1'b1);
        cyc(4);
        chk(den === 1'b1 && busy === 1'b1, "R7", "window holds during stream", int'(den), 1);
        sdone = 1'b1; @(negedge clk); sdone = 1'b0;
        cyc(3);
        chk(xreq === 1'b0 && busy === 1'b1, "R7", "polling while done low", int'(xreq), 0);
        p_cdone = 1'b1;
        k = 0;
        while (xreq !== 1'b1 && k < 10) begin @(negedge clk); k++; end
        chk(xreq === 1'b1, "R8", "extra clock request", int'(xreq), 1);
        chk(xnum === 4'(XDC), "R8", "extra clock count", int'(xnum), XDC);
        cyc(3);
        chk(xreq === 1'b1, "R8", "request held until ack", int'(xreq), 1);
        ack = 1'b1; @(negedge clk); ack = 1'b0;
        cyc(2);
        p_user = 1'b1;
        k = 0;
        while (cen !== 1'b0 && k < 10) begin @(negedge clk); k++; end
        chk({cen, den, covr, ncovr, nce} === 5'b00111, "R9", "close drives",
            int'({cen, den, covr, ncovr, nce}), 5'b00111);
        expect_end("R10", 0);
        pins_default();
    endtask

    task automatic t_postchk_fail();
        to_window(3'd0, 1'b0);
        expect_end("R6", 3);
        pins_default();
    endtask

    task automatic t_poll_nstat();
        to_window(3'd1, 1'b1);
        sdone = 1'b1; @(negedge clk); sdone = 1'b0;
        cyc(2);
        p_nstat = 1'b0;
        expect_end("R7", 3);
        pins_default();
    endtask

    task automatic t_poll_exhaust();
        to_window(3'd0, 1'b1);
        sdone = 1'b1; @(negedge clk); sdone = 1'b0;
        cyc(POLL - 3);
        chk(busy === 1'b1 && done === 1'b0, "R7", "still polling before limit", int'(busy), 1);
        expect_end("R7", 2);
        pins_default();
    endtask

    task automatic t_user_timeout();
        to_window(3'd0, 1'b1);
        sdone = 1'b1; @(negedge clk); sdone = 1'b0;
        p_cdone = 1'b1;
        cyc(3);
        ack = 1'b1; @(negedge clk); ack = 1'b0;
        expect_end("R8", 2);
        pins_default();
    endtask

    task automatic t_final_fail();
        to_window(3'd0, 1'b1);
        sdone = 1'b1; @(negedge clk); sdone = 1'b0;
        p_cdone = 1'b1;
        cyc(3);
        ack = 1'b1; @(negedge clk); ack = 1'b0;
        p_user = 1'b1; p_cdone = 1'b0;
        expect_end("R10", 3);
        pins_default();
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_bad_mode();
        t_quiet_timeout();
        t_full_ok(3'd0);
        t_full_ok(3'd1);
        t_postchk_fail();
        t_poll_nstat();
        t_poll_exhaust();
        t_user_timeout();
        t_final_fail();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule